// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

This block collects 64 level-sensitive interrupt sources and presents them to a processor on two outputs. One output carries normal interrupts and the other carries fast interrupts. Each source has an enable bit, a routing bit that picks the output it drives, a 4-bit priority and a software force bit. A 5-bit mask level can hold back normal sources of low priority. Every per-source bitmap takes two 32-bit words. The low word holds sources 0 to 31.

Software can enable or disable a single source with one write of its number to a command register, so no read-modify-write is needed. This is also how a source is acknowledged: the handler disables it, services the device, and enables it again. Two vector/status registers name the source that currently wins. The normal one picks by priority and the fast one by source number. The pending bitmaps show the full picture.

The register bus uses byte addresses. A write takes effect at the next rising clock edge. Read data is combinational from the address.

Top module: `vic_two_level`

## Requirements
- R1: After reset, every enable, routing, priority and force bit is 0, the control word is 0, the mask level reads 0x1F, and both interrupt outputs are low.
- R2: Writing n (0 to 63) to offset 0x08 sets the enable bit of source n, and writing n to 0x0C clears it. No other enable bit changes. Writes of values above 63 to either offset change nothing. Reads of both offsets return 0.
- R3: The enable bitmap can be read and written directly. Sources 32 to 63 are at 0x10 and sources 0 to 31 are at 0x14, with bit i of each word meaning source i of that half.
- R4: The routing bitmaps are at 0x18 (high) and 0x1C (low). A 1 sends the source to the fast output and a 0 sends it to the normal output.
- R5: Priority of source n is held in bits 4*(n%8)+3 down to 4*(n%8) of group n/8. Group g is read and written at offset 0x20+4*(7-g).
- R6: The mask level at 0x04 is 5 bits wide. When its bit 4 is set, no source is blocked. Otherwise a normal source whose priority is less than or equal to bits 3:0 is blocked from the normal output and the normal vector. Fast sources are never masked.
- R7: The raw source inputs read at 0x48 (high) and 0x4C (low). The force bitmaps at 0x50 (high) and 0x54 (low) make a source active exactly as a high raw input does.
- R8: Normal pending (0x58 high, 0x5C low) equals (raw OR force) AND enable AND NOT route. Fast pending (0x60 high, 0x64 low) equals (raw OR force) AND enable AND route. Neither bitmap depends on the mask.
- R9: The normal output is high exactly when some normal pending source is not blocked. The fast output is high exactly when some fast pending bit is set.
- R10: Offset 0x40 reads {source number in bits 31:16, priority in bits 15:0} for the unblocked normal pending source with the highest priority. A tie goes to the higher source number. With no such source it reads 0xFFFFFFFF.
- R11: Offset 0x44 reads {source number, priority} in the same layout for the highest-numbered fast pending source, and reads 0xFFFFFFFF when none is pending.
- R12: The control word at 0x00 is a 32-bit read/write register that resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 7 | Byte address of the register |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| src_in | input | 64 | Raw level-sensitive interrupt sources |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
Random rounds mix random raw inputs, random force bits, random routing, random priorities and random mask levels. Under this mix, the normal vector has to choose by priority and not by source number, and the fast vector has to choose by number alone. Directed cases add equal priorities on two sources, which checks the tie rule. They also place a source's priority exactly at the mask level and one step above it, which separates "less than" from "less than or equal". The number registers get out-of-range values, and single-bit number writes are made next to a full bitmap, to show that the other enable bits are left alone. A write to one priority word is read back through the vector of a source in that group, which confirms the reversed group order.

// File: rtl/vic_two_level.sv
module vic_two_level #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [63:0]   src_in,
  output logic          irq_norm,
  output logic          irq_fast
);
  localparam int NSRC = 64;
  localparam int NGRP = NSRC / 8;
  localparam logic [DW-1:0] NONE = '1;

  logic [DW-1:0]   ctrl_q;
  logic [4:0]      lvl_q;
  logic [NSRC-1:0] en_q, route_q, frc_q;
  logic [3:0]      pri_q [NSRC];

  logic [4:0]      widx;
  logic            num_ok;
  logic [NSRC-1:0] act, np, fp, nvis;
  logic [DW-1:0]   nvec, fvec;

  assign widx   = bus_addr[6:2];
  assign num_ok = (bus_wdata[DW-1:6] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      lvl_q   <= 5'h1F;
      en_q    <= '0;
      route_q <= '0;
      frc_q   <= '0;
      for (int n = 0; n < NSRC; n++) pri_q[n] <= '0;
    end else if (bus_wr) begin
      case (widx)
        5'd0:  ctrl_q <= bus_wdata;
        5'd1:  lvl_q <= bus_wdata[4:0];
        5'd2:  if (num_ok) en_q[bus_wdata[5:0]] <= 1'b1;
        5'd3:  if (num_ok) en_q[bus_wdata[5:0]] <= 1'b0;
        5'd4:  en_q[63:32] <= bus_wdata;
        5'd5:  en_q[31:0] <= bus_wdata;
        5'd6:  route_q[63:32] <= bus_wdata;
        5'd7:  route_q[31:0] <= bus_wdata;
        5'd20: frc_q[63:32] <= bus_wdata;
        5'd21: frc_q[31:0] <= bus_wdata;
        default:
          if (widx[4:3] == 2'b01)
            for (int k = 0; k < 8; k++)
              pri_q[(7 - int'(widx[2:0])) * 8 + k] <= bus_wdata[4*k +: 4];
      endcase
    end
  end

  assign act = src_in | frc_q;
  assign np  = act & en_q & ~route_q;
  assign fp  = act & en_q & route_q;

  always_comb begin
    for (int n = 0; n < NSRC; n++)
      nvis[n] = np[n] && (lvl_q[4] || (pri_q[n] > lvl_q[3:0]));
  end

  assign irq_norm = |nvis;
  assign irq_fast = |fp;

  always_comb begin
    logic [3:0] best;
    logic       hit;
    best = '0;
    hit  = 1'b0;
    nvec = NONE;
    for (int n = 0; n < NSRC; n++)
      if (nvis[n] && (!hit || pri_q[n] >= best)) begin
        hit  = 1'b1;
        best = pri_q[n];
        nvec = {16'(n), 12'd0, pri_q[n]};
      end
  end

  always_comb begin
    fvec = NONE;
    for (int n = 0; n < NSRC; n++)
      if (fp[n]) fvec = {16'(n), 12'd0, pri_q[n]};
  end

  always_comb begin
    bus_rdata = '0;
    case (widx)
      5'd0:  bus_rdata = ctrl_q;
      5'd1:  bus_rdata = {27'd0, lvl_q};
      5'd4:  bus_rdata = en_q[63:32];
      5'd5:  bus_rdata = en_q[31:0];
      5'd6:  bus_rdata = route_q[63:32];
      5'd7:  bus_rdata = route_q[31:0];
      5'd16: bus_rdata = nvec;
      5'd17: bus_rdata = fvec;
      5'd18: bus_rdata = src_in[63:32];
      5'd19: bus_rdata = src_in[31:0];
      5'd20: bus_rdata = frc_q[63:32];
      5'd21: bus_rdata = frc_q[31:0];
      5'd22: bus_rdata = np[63:32];
      5'd23: bus_rdata = np[31:0];
      5'd24: bus_rdata = fp[63:32];
      5'd25: bus_rdata = fp[31:0];
      default:
        if (widx[4:3] == 2'b01)
          for (int k = 0; k < 8; k++)
            bus_rdata[4*k +: 4] = pri_q[(7 - int'(widx[2:0])) * 8 + k];
    endcase
  end
endmodule

module vic_two_level_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [6:0]  bus_addr,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [63:0] en_q,
  input logic [63:0] route_q,
  input logic        irq_norm,
  input logic        irq_fast,
  input logic [31:0] nvec
);
  AST_ENNUM_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 7'h08) |=> ($countones(en_q ^ $past(en_q)) <= 1)); // R2
  AST_DISNUM_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 7'h0C) |=> ((en_q & ~$past(en_q)) == 64'd0)); // R2
  AST_BIGNUM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == 7'h08 || bus_addr == 7'h0C) && bus_wdata > 32'd63) |=> $stable(en_q)); // R2
  AST_FAST_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |-> ((en_q & route_q) != 64'd0)); // R4
  AST_NORM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm |-> ((en_q & ~route_q) != 64'd0)); // R9
  AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_norm |-> (nvec == 32'hFFFF_FFFF)); // R10
  AST_VEC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm |-> (nvec[31:22] == 10'd0)); // R10
endmodule

bind vic_two_level vic_two_level_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .en_q(en_q), .route_q(route_q),
  .irq_norm(irq_norm), .irq_fast(irq_fast), .nvec(nvec)
);

// File: tb/vic_two_level_bench.sv
`timescale 1ns/1ps
module vic_two_level_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        irq_norm, irq_fast;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_ctrl;
  logic [4:0]  m_lvl;
  logic [63:0] m_en, m_rt, m_fc;
  logic [3:0]  m_pr [64];

  vic_two_level u_vic_two_level (.*);

  always #5 clk = ~clk;

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      7'h00: m_ctrl = d;
      7'h04: m_lvl = d[4:0];
      7'h08: if (d < 64) m_en[d[5:0]] = 1'b1;
      7'h0C: if (d < 64) m_en[d[5:0]] = 1'b0;
      7'h10: m_en[63:32] = d;
      7'h14: m_en[31:0] = d;
      7'h18: m_rt[63:32] = d;
      7'h1C: m_rt[31:0] = d;
      7'h50: m_fc[63:32] = d;
      7'h54: m_fc[31:0] = d;
      default:
        if (a >= 7'h20 && a <= 7'h3C)
          for (int k = 0; k < 8; k++) m_pr[(7 - int'((a - 7'h20) >> 2)) * 8 + k] = d[4*k +: 4];
    endcase
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [63:0] e_np();
    return (src_in | m_fc) & m_en & ~m_rt;
  endfunction
  function automatic logic [63:0] e_fp();
    return (src_in | m_fc) & m_en & m_rt;
  endfunction
  function automatic logic e_vis(input int n);
    logic [63:0] p;
    p = e_np();
    return p[n] && (m_lvl[4] || m_pr[n] > m_lvl[3:0]);
  endfunction
  function automatic logic [31:0] e_nvec();
    logic [31:0] v;
    int bp;
    v = 32'hFFFF_FFFF;
    bp = -1;
    for (int n = 0; n < 64; n++)
      if (e_vis(n) && int'(m_pr[n]) >= bp) begin
        bp = int'(m_pr[n]);
        v = {16'(n), 16'(m_pr[n])};
      end
    return v;
  endfunction
  function automatic logic [31:0] e_fvec();
    logic [31:0] v;
    logic [63:0] p;
    v = 32'hFFFF_FFFF;
    p = e_fp();
    for (int n = 0; n < 64; n++) if (p[n]) v = {16'(n), 16'(m_pr[n])};
    return v;
  endfunction
  function automatic logic e_irq();
    logic r;
    r = 1'b0;
    for (int n = 0; n < 64; n++) r |= e_vis(n);
    return r;
  endfunction

  task automatic check_all();
    logic [31:0] d;
    logic [63:0] np, fp;
    np = e_np(); fp = e_fp();
    #1;
    chk("R9 irq_norm", 32'(irq_norm), 32'(e_irq()));
    chk("R9 irq_fast", 32'(irq_fast), 32'(|fp));
    rd(7'h40, d); chk("R10 normal vector", d, e_nvec());
    rd(7'h44, d); chk("R11 fast vector", d, e_fvec());
    rd(7'h58, d); chk("R8 normal pending high", d, np[63:32]);
    rd(7'h5C, d); chk("R8 normal pending low", d, np[31:0]);
    rd(7'h60, d); chk("R8 fast pending high", d, fp[63:32]);
    rd(7'h64, d); chk("R8 fast pending low", d, fp[31:0]);
    rd(7'h48, d); chk("R7 raw high", d, src_in[63:32]);
    rd(7'h4C, d); chk("R7 raw low", d, src_in[31:0]);
    rd(7'h50, d); chk("R7 force high", d, m_fc[63:32]);
    rd(7'h10, d); chk("R3 enable high", d, m_en[63:32]);
    rd(7'h14, d); chk("R3 enable low", d, m_en[31:0]);
    rd(7'h1C, d); chk("R4 route low", d, m_rt[31:0]);
    rd(7'h04, d); chk("R6 mask level", d, {27'd0, m_lvl});
    rd(7'h00, d); chk("R12 control", d, m_ctrl);
    for (int g = 0; g < 8; g++) begin
      logic [31:0] w;
      for (int k = 0; k < 8; k++) w[4*k +: 4] = m_pr[g*8 + k];
      rd(7'(32 + 4 * (7 - g)), d); chk("R5 priority word", d, w);
    end
  endtask

  logic [31:0] rv;

  initial begin
    void'($urandom(32'd20240611));
    m_ctrl = '0; m_lvl = 5'h1F; m_en = '0; m_rt = '0; m_fc = '0;
    for (int n = 0; n < 64; n++) m_pr[n] = '0;
    src_in = {32'hFFFF_FFFF, 32'hFFFF_FFFF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    #1;
    chk("R1 irq_norm at reset", 32'(irq_norm), 32'd0);
    chk("R1 irq_fast at reset", 32'(irq_fast), 32'd0);
    rd(7'h04, rv); chk("R1 mask level at reset", rv, 32'h1F);
    check_all();

    // R2 number registers
    src_in = '0;
    bw(7'h14, 32'hF0F0_0000);
    bw(7'h08, 32'd5);
    rd(7'h14, rv); chk("R2 enable-number sets one bit", rv, 32'hF0F0_0020);
    bw(7'h0C, 32'd20);
    rd(7'h14, rv); chk("R2 disable-number clears one bit", rv, 32'hF0E0_0020);
    bw(7'h08, 32'd70);
    bw(7'h0C, 32'd64);
    rd(7'h14, rv); chk("R2 out-of-range number ignored low", rv, 32'hF0E0_0020);
    rd(7'h10, rv); chk("R2 out-of-range number ignored high", rv, 32'h0);
    bw(7'h08, 32'd63);
    rd(7'h10, rv); chk("R2 enable source 63", rv, 32'h8000_0000);
    rd(7'h08, rv); chk("R2 enable-number reads zero", rv, 32'h0);
    rd(7'h0C, rv); chk("R2 disable-number reads zero", rv, 32'h0);

    // R5 reversed group order, R10 tie to higher number
    bw(7'h14, 32'h0); bw(7'h10, 32'h0);
    bw(7'h04, 32'h10);
    bw(7'h20, 32'h0000_0009);  // group 7 -> source 56 priority 9
    bw(7'h08, 32'd56);
    bw(7'h54, 32'h0);
    src_in = 64'd1 << 56;
    check_all();
    rd(7'h40, rv); chk("R5 group 7 at lowest priority offset", rv, {16'd56, 16'd9});
    src_in = (64'd1 << 3) | (64'd1 << 10);
    bw(7'h08, 32'd3); bw(7'h08, 32'd10);
    rd(7'h40, rv); chk("R10 tie goes to higher number", rv, {16'd10, 16'd0});

    // R6 mask boundary
    bw(7'h3C, 32'h0000_3000);  // group 0 -> source 3 priority 3
    bw(7'h04, 32'h03);
    #1; chk("R6 priority equal to level blocked", 32'(irq_norm), 32'd0);
    bw(7'h04, 32'h02);
    rd(7'h40, rv); chk("R6 priority above level passes", rv, {16'd3, 16'd3});
    bw(7'h1C, 32'h0000_0400);
    bw(7'h04, 32'h0F);
    rd(7'h44, rv); chk("R11 fast source ignores mask", rv, {16'd10, 16'd0});
    check_all();

    // random rounds
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0: bw(7'h08, $urandom_range(0, 80));
        1: bw(7'h0C, $urandom_range(0, 80));
        2: bw($urandom_range(0, 1) ? 7'h10 : 7'h14, $urandom);
        3: bw($urandom_range(0, 1) ? 7'h18 : 7'h1C, $urandom);
        4: bw(7'(32 + 4 * $urandom_range(0, 7)), $urandom);
        5: bw(7'h04, $urandom_range(0, 31));
        6: bw($urandom_range(0, 1) ? 7'h50 : 7'h54, $urandom & $urandom & $urandom);
        7: bw(7'h00, $urandom);
        default: ;
      endcase
      src_in = {$urandom & $urandom, $urandom & $urandom};
      check_all();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule